// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block sits beside a small 8-bit CPU core and decides which of six interrupt sources gets serviced next. Each source has a raw request flag, a bit in an enable register, and two priority bits that give it one of four levels. In every cycle the block picks the best pending request: the highest level first, then a fixed polling order within a level. It raises a request towards the CPU only if that request may preempt the handler that is already running.

When the CPU acknowledges, the block records the granted source and level and marks that level as in service. A return-from-interrupt strobe retires the most recently entered level, which is the highest in-service level. Handlers therefore nest strictly by level, up to four deep. Edge and level detection of the external pins, and clearing of the source flags, are handled outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0, `in_service` is 0000b and `grant_src`/`grant_lvl` are 0.
- R2: When enable bit 7 (global enable) is 0, no request is raised, whatever the flags and per-source enable bits are.
- R3: Source index i (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2) is gated by enable bit i. Enable bit 6 has no effect.
- R4: The serial source is pending when its receive flag or its transmit flag is set. The timer 2 source is pending when its overflow flag or its external flag is set.
- R5: A source's level is {prio_hi[i], prio_lo[i]}, with 0 the lowest and 3 the highest. Among pending requests, the highest level is chosen.
- R6: Among pending requests of equal level, the lowest source index wins.
- R7: The offered vector is 0003h + 8 × source index (0003h, 000Bh, 0013h, 001Bh, 0023h, 002Bh).
- R8: A request appears on `irq_req` one clock after it becomes eligible. It then stays asserted, with vector, source and level unchanged, until `irq_ack` is sampled high, even if the flag drops.
- R9: An acknowledge while `irq_req` is high latches the offered source and level into `grant_src`/`grant_lvl` and sets the in-service bit for that level. `irq_req` is low in the next cycle. An acknowledge while `irq_req` is low is ignored.
- R10: A new request is raised only if no level is in service or its level is strictly above the highest in-service level. A level-3 handler is therefore never preempted.
- R11: A return-from-interrupt strobe clears the highest set in-service bit. If it coincides with an acknowledge, the clear applies to the old mask before the new level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_flag | input | 1 | External interrupt 0 flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External interrupt 1 flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive-done flag |
| ser_tx_flag | input | 1 | Serial transmit-done flag |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag |
| tmr2_ext_flag | input | 1 | Timer 2 external event flag |
| irq_en | input | 8 | Enable register (bit 7 global, bits 5..0 per source) |
| irq_prio_lo | input | 8 | Low priority bit per source (bits 5..0) |
| irq_prio_hi | input | 8 | High priority bit per source (bits 5..0) |
| irq_ack | input | 1 | CPU acknowledge of the offered request |
| irq_reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request towards the CPU |
| irq_vector | output | 16 | Vector address of the offered request |
| irq_src | output | 3 | Source index of the offered request |
| irq_lvl | output | 2 | Level of the offered request |
| grant_src | output | 3 | Source index latched at the last acknowledge |
| grant_lvl | output | 2 | Level latched at the last acknowledge |
| in_service | output | 4 | One bit per level currently in service |

## Verification
The hardest state to reach is a deep nest: three levels in service, with a level-3 handler on top, while an equally ranked request waits and must stay blocked. A single reti must then unblock exactly that request. A directed sequence builds this nest step by step by raising levels 1, 2 and 3 in turn and acknowledging each. A long random phase follows that mixes sparse flags, random priorities, random acknowledges and return strobes. Every cycle of that phase is compared against a bench model of the nesting rules.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_SRC_N  = 6;
  localparam int IRQ_LVL_W  = 2;
  localparam int IRQ_LVL_N  = 1 << IRQ_LVL_W;
  localparam int IRQ_IDX_W  = $clog2(IRQ_SRC_N);
  localparam int IRQ_REG_W  = 8;
  localparam int IRQ_GEN_BIT = 7;

  typedef logic [IRQ_LVL_W-1:0] lvl_t;
  typedef logic [IRQ_IDX_W-1:0] idx_t;

  typedef struct packed {
    logic valid;
    idx_t idx;
    lvl_t lvl;
  } cand_t;
endpackage

// File: rtl/irq_src_gather.sv
module irq_src_gather
  import irq_pkg::*;
#(
  parameter int N     = IRQ_SRC_N,
  parameter int REG_W = IRQ_REG_W,
  parameter int GEN   = IRQ_GEN_BIT
) (
  input  logic [N-1:0]     raw_req,
  input  logic [REG_W-1:0] en_reg,
  input  logic [REG_W-1:0] prio_lo,
  input  logic [REG_W-1:0] prio_hi,
  output logic [N-1:0]     pend,
  output lvl_t             lvl [N]
);
  // One gate and one level pair per source; bit position equals source index.
  for (genvar i = 0; i < N; i++) begin : g_src
    assign pend[i] = raw_req[i] & en_reg[i] & en_reg[GEN];
    assign lvl[i]  = {prio_hi[i], prio_lo[i]};
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N     = IRQ_SRC_N,
  parameter int LVL_N = IRQ_LVL_N
) (
  input  logic [N-1:0] pend,
  input  lvl_t         lvl [N],
  output cand_t        win
);
  logic [N-1:0] hit [LVL_N];

  for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign hit[l][i] = pend[i] && (lvl[i] == lvl_t'(l));
    end
  end

  // Later iterations override earlier ones: a higher level beats a lower
  // one, and within a level the lower index (visited last) wins.
  always_comb begin
    win = '0;
    for (int l = 0; l < LVL_N; l++) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (hit[l][i]) begin
          win.valid = 1'b1;
          win.idx   = idx_t'(i);
          win.lvl   = lvl_t'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
  import irq_pkg::*;
#(
  parameter int LVL_N = IRQ_LVL_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  lvl_t             set_lvl,
  input  logic             clr_top,
  output logic [LVL_N-1:0] svc,
  output logic             busy,
  output lvl_t             cur_lvl
);
  logic [LVL_N-1:0] top_oh;
  logic [LVL_N-1:0] svc_nxt;

  always_comb begin
    top_oh  = '0;
    cur_lvl = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (svc[l]) begin
        top_oh    = '0;
        top_oh[l] = 1'b1;
        cur_lvl   = lvl_t'(l);
      end
    end
  end

  assign busy = |svc;

  always_comb begin
    svc_nxt = svc;
    if (clr_top) svc_nxt = svc_nxt & ~top_oh;
    if (set_en)  svc_nxt = svc_nxt | (LVL_N'(1) << set_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) svc <= '0;
    else     svc <= svc_nxt;
  end

  // Requirement R11: a lone return strobe removes exactly one in-service level.
  assert_reti_one_R11: assert property (@(posedge clk) disable iff (rst)
    (clr_top && !set_en && busy) |=> ($countones(svc) == $past($countones(svc)) - 1));

  // Requirement R9: an acknowledged level is marked in service.
  assert_ack_marks_R9: assert property (@(posedge clk) disable iff (rst)
    set_en |=> svc[$past(set_lvl)]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int          N        = IRQ_SRC_N,
  parameter int          LVL_N    = IRQ_LVL_N,
  parameter int          REG_W    = IRQ_REG_W,
  parameter int          ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 16'h0003,
  parameter int unsigned VEC_STEP = 16'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext0_flag,
  input  logic              tmr0_flag,
  input  logic              ext1_flag,
  input  logic              tmr1_flag,
  input  logic              ser_rx_flag,
  input  logic              ser_tx_flag,
  input  logic              tmr2_ovf_flag,
  input  logic              tmr2_ext_flag,
  input  logic [REG_W-1:0]  irq_en,
  input  logic [REG_W-1:0]  irq_prio_lo,
  input  logic [REG_W-1:0]  irq_prio_hi,
  input  logic              irq_ack,
  input  logic              irq_reti,
  output logic              irq_req,
  output logic [ADDR_W-1:0] irq_vector,
  output logic [IRQ_IDX_W-1:0] irq_src,
  output logic [IRQ_LVL_W-1:0] irq_lvl,
  output logic [IRQ_IDX_W-1:0] grant_src,
  output logic [IRQ_LVL_W-1:0] grant_lvl,
  output logic [LVL_N-1:0]  in_service
);
  logic [N-1:0] raw_req;
  logic [N-1:0] pend;
  lvl_t         src_lvl [N];
  cand_t        win;
  logic         svc_busy;
  lvl_t         cur_lvl;
  logic         may_preempt;
  logic         take;

  assign raw_req = {tmr2_ovf_flag | tmr2_ext_flag,
                    ser_rx_flag | ser_tx_flag,
                    tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};

  irq_src_gather #(.N(N), .REG_W(REG_W), .GEN(IRQ_GEN_BIT)) u_gather (
    .raw_req (raw_req),
    .en_reg  (irq_en),
    .prio_lo (irq_prio_lo),
    .prio_hi (irq_prio_hi),
    .pend    (pend),
    .lvl     (src_lvl)
  );

  irq_arbiter #(.N(N), .LVL_N(LVL_N)) u_arb (
    .pend (pend),
    .lvl  (src_lvl),
    .win  (win)
  );

  assign take = irq_req && irq_ack;

  irq_svc_tracker #(.LVL_N(LVL_N)) u_svc (
    .clk     (clk),
    .rst     (rst),
    .set_en  (take),
    .set_lvl (irq_lvl),
    .clr_top (irq_reti),
    .svc     (in_service),
    .busy    (svc_busy),
    .cur_lvl (cur_lvl)
  );

  assign may_preempt = !svc_busy || (win.lvl > cur_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
      irq_src    <= '0;
      irq_lvl    <= '0;
      grant_src  <= '0;
      grant_lvl  <= '0;
    end else if (irq_req) begin
      if (irq_ack) begin
        irq_req   <= 1'b0;
        grant_src <= irq_src;
        grant_lvl <= irq_lvl;
      end
    end else if (win.valid && may_preempt) begin
      irq_req    <= 1'b1;
      irq_src    <= win.idx;
      irq_lvl    <= win.lvl;
      irq_vector <= ADDR_W'(VEC_BASE) + ADDR_W'(win.idx) * ADDR_W'(VEC_STEP);
    end
  end

  // Requirement R8: an unacknowledged request holds with a stable vector.
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector) && $stable(irq_lvl)));

  // Requirement R9: acknowledge ends the request in the next cycle.
  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> !irq_req);

  // Requirement R10: a new request outranks whatever was in service.
  assert_preempt_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> (!$past(svc_busy) || (irq_lvl > $past(cur_lvl))));

  // Requirement R10: a level-3 handler is never preempted.
  assert_top_lvl_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(in_service[LVL_N-1]));

  // Requirement R2: no request rises while the global enable is off.
  assert_global_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(irq_en[IRQ_GEN_BIT]));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst;
  logic ext0, tmr0, ext1, tmr1, srx, stx, t2o, t2e;
  logic [7:0] en_r, plo, phi;
  logic ack, reti;
  logic        req;
  logic [15:0] vec;
  logic [2:0]  src, gsrc;
  logic [1:0]  lvl, glvl;
  logic [3:0]  ins;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic       m_req;
  int         m_src, m_lvl, m_gsrc, m_glvl;
  logic [3:0] m_ins;

  always #5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst),
    .ext0_flag(ext0), .tmr0_flag(tmr0), .ext1_flag(ext1), .tmr1_flag(tmr1),
    .ser_rx_flag(srx), .ser_tx_flag(stx), .tmr2_ovf_flag(t2o), .tmr2_ext_flag(t2e),
    .irq_en(en_r), .irq_prio_lo(plo), .irq_prio_hi(phi),
    .irq_ack(ack), .irq_reti(reti),
    .irq_req(req), .irq_vector(vec), .irq_src(src), .irq_lvl(lvl),
    .grant_src(gsrc), .grant_lvl(glvl), .in_service(ins)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] f_pend();
    logic [5:0] r;
    r = {t2o | t2e, srx | stx, tmr1, ext1, tmr0, ext0};
    return en_r[7] ? (r & en_r[5:0]) : 6'b0;
  endfunction

  function automatic int f_top(logic [3:0] m);
    int t = -1;
    for (int l = 0; l < 4; l++) if (m[l]) t = l;
    return t;
  endfunction

  task automatic cyc();
    logic [5:0] p;
    int wi, wl, top;
    logic [3:0] ni;
    logic nreq;
    int nsrc, nlvl, ngs, ngl;
    p = f_pend();
    wi = -1; wl = -1;
    for (int l = 3; l >= 0 && wi < 0; l--)
      for (int i = 0; i < 6 && wi < 0; i++)
        if (p[i] && ({phi[i], plo[i]} == 2'(l))) begin wi = i; wl = l; end
    top = f_top(m_ins);
    ni = m_ins;
    if (reti && top >= 0) ni[top] = 1'b0;
    nreq = m_req; nsrc = m_src; nlvl = m_lvl; ngs = m_gsrc; ngl = m_glvl;
    if (m_req) begin
      if (ack) begin
        nreq = 1'b0; ngs = m_src; ngl = m_lvl; ni[m_lvl] = 1'b1;
      end
    end else if (wi >= 0 && (top < 0 || wl > top)) begin
      nreq = 1'b1; nsrc = wi; nlvl = wl;
    end
    @(posedge clk);
    @(negedge clk);
    m_req = nreq; m_src = nsrc; m_lvl = nlvl; m_gsrc = ngs; m_glvl = ngl; m_ins = ni;
    chk("R8 R10 req", int'(req), int'(m_req));
    if (m_req) begin
      chk("R7 vector", int'(vec), 3 + 8 * m_src);
      chk("R5 R6 level", int'(lvl), m_lvl);
    end
    chk("R9 grant src", int'(gsrc), m_gsrc);
    chk("R9 grant lvl", int'(glvl), m_glvl);
    chk("R11 in_service", int'(ins), int'(m_ins));
  endtask

  task automatic flags(logic [7:0] f);
    {t2e, t2o, stx, srx, tmr1, ext1, tmr0, ext0} = f;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; flags(8'h00); en_r = 0; plo = 0; phi = 0; ack = 0; reti = 0;
    m_req = 0; m_src = 0; m_lvl = 0; m_gsrc = 0; m_glvl = 0; m_ins = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset req", int'(req), 0);
    chk("R1 reset in_service", int'(ins), 0);
    chk("R1 reset grant", int'({gsrc, glvl}), 0);

    // R2: global enable off masks everything
    en_r = 8'h3F; flags(8'hFF);
    repeat (3) cyc();
    chk("R2 global mask", int'(req), 0);

    // R3: bit 6 alone enables nothing
    en_r = 8'hC0;
    repeat (2) cyc();
    chk("R3 bit6 ignored", int'(req), 0);

    // R4/R7: serial via transmit flag
    flags(8'h00); stx = 1; en_r = 8'h90;
    cyc();
    chk("R4 serial tx req", int'(req), 1);
    chk("R7 serial vector", int'(vec), 16'h0023);
    ack = 1; stx = 0; cyc(); ack = 0;
    chk("R9 grant serial", int'(gsrc), 4);
    chk("R9 in_service lvl0", int'(ins), 4'b0001);
    reti = 1; cyc(); reti = 0;
    chk("R11 reti clears", int'(ins), 0);

    // R4: timer 2 via external flag
    t2e = 1; en_r = 8'hA0;
    cyc();
    chk("R4 tmr2 ext vector", int'(vec), 16'h002B);
    ack = 1; t2e = 0; cyc(); ack = 0;
    reti = 1; cyc(); reti = 0;

    // R5: higher level beats earlier poll position; R8 hold after flag drop
    en_r = 8'hBF; phi = 8'h20; plo = 8'h00; ext0 = 1; t2o = 1;
    cyc();
    chk("R5 level wins", int'(src), 5);
    chk("R5 level value", int'(lvl), 2);
    flags(8'h00);
    repeat (2) cyc();
    chk("R8 held req", int'(req), 1);
    chk("R8 held vector", int'(vec), 16'h002B);
    ack = 1; cyc(); ack = 0;
    chk("R9 grant lvl2", int'(glvl), 2);
    chk("R9 in_service lvl2", int'(ins), 4'b0100);
    reti = 1; cyc(); reti = 0;

    // R6: tie at level 1 between external 1 and timer 1
    phi = 8'h00; plo = 8'h0C; ext1 = 1; tmr1 = 1;
    cyc();
    chk("R6 tie poll order", int'(vec), 16'h0013);
    ack = 1; flags(8'h00); cyc(); ack = 0;
    reti = 1; cyc(); reti = 0;

    // R10: nesting
    plo = 8'h01; phi = 8'h00; ext0 = 1;
    cyc(); ack = 1; cyc(); ack = 0;
    repeat (2) cyc();
    chk("R10 same level blocked", int'(req), 0);
    phi = 8'h02; plo = 8'h01; tmr0 = 1;
    cyc();
    chk("R10 higher preempts", int'(src), 1);
    ack = 1; cyc(); ack = 0;
    phi = 8'h0A; plo = 8'h09; tmr1 = 1;
    cyc();
    chk("R10 level3 preempts", int'(lvl), 3);
    ack = 1; cyc(); ack = 0;
    chk("R10 nest mask", int'(ins), 4'b1110);
    phi = 8'h0E; plo = 8'h0D; ext1 = 1;
    repeat (3) cyc();
    chk("R10 level3 not preempted", int'(req), 0);
    reti = 1; cyc(); reti = 0;
    chk("R11 top cleared", int'(ins), 4'b0110);
    cyc();
    chk("R10 unblocked after reti", int'(src), 2);
    flags(8'h00); ack = 1; cyc(); ack = 0;
    reti = 1; repeat (3) cyc(); reti = 0;
    chk("R11 drained", int'(ins), 0);

    // R11: reti coinciding with acknowledge
    phi = 8'h00; plo = 8'h00; ext0 = 1; en_r = 8'h81;
    cyc();
    ack = 1; reti = 1; ext0 = 0; cyc(); ack = 0; reti = 0;
    chk("R11 reti with ack", int'(ins), 4'b0001);
    reti = 1; cyc(); reti = 0;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] f;
      for (int b = 0; b < 8; b++) f[b] = ($urandom % 5) == 0;
      flags(f);
      if (n % 16 == 0) begin
        en_r = 8'($urandom);
        if ($urandom % 6 != 0) en_r[7] = 1'b1;
        plo = 8'($urandom); phi = 8'($urandom);
      end
      ack  = ($urandom % 3) == 0;
      reti = ($urandom % 4) == 0;
      cyc();
    end
    ack = 0; reti = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule